// File: doc/BRIEF.md
# Indexed Remap Index Prefetch Cache

This block keeps a local copy of the permutation indices that a vector loop uses to remap its element steps. A capture begins on any of three pulses: an index-setup command, a write to a shape configuration register, or a write to the maximum vector length. The block then walks a contiguous run of register-file entries, starting at a base register number and covering as many entries as the maximum vector length, through a read port that it shares with other work. Each returned value is cut to its low 8 bits and written into a small table. While this capture runs, the block raises a hazard-busy signal that covers the whole index range and the length setting. Once the capture ends, the block no longer looks at the register file. It does not see later writes to the index registers and does not track them.

During the loop, a step number comes in on a valid/ready stream. The block takes the step modulo the captured length as a table entry and returns the stored index one cycle later on a second valid/ready stream. With it, it returns the step's parallelism group, which is the raw step divided by the length. A lookup waits, with ready low, until its own entry has arrived, so early entries can be used before the capture is complete. Both streams follow the usual rule: a transfer takes place on a clock edge where valid and ready are both high. The lookup output holds index and group stable while its ready is low. The lookup input does not need to hold, and it is taken only when the entry is present and the output slot is free or draining. On the read-request side, the address stays stable until it is granted. Responses arrive in order, one per granted request, and have no back-pressure.

An index that is larger than the length minus one is out of range. It is clamped to length minus one, and a sticky flag is raised. Two steps that map to the same index pass through unchanged, with no conflict check.

Top module: `idx_remap_cache`

## Requirements
- R1: A one-cycle pulse on `cap_req`, `shape_wr` or `mvl_wr` starts a capture. In the next cycle `hazard_busy` is 1 and every table entry is invalid, so `lk_ready` is 0. `lk_ready` is also 0 in the cycle of the pulse itself.
- R2: A capture issues read requests for addresses base+0, base+1, … base+(L-1), in that order and modulo 2^7. L is the sampled `cfg_maxvl`: 0 is taken as 1 and values above 64 as 64. At most one request is outstanding, and a request's address holds until `rd_req_ready` grants it.
- R3: `hazard_busy` stays at 1 until all L responses have been stored, then falls to 0. While it is 0, `rd_req_valid` stays 0, so register writes after the capture cannot reach the table.
- R4: A step is accepted only after table entry (step mod L) has been stored during the current capture.
- R5: An accepted step produces `o_valid` in the next cycle. While `o_ready` is 0, `o_valid`, `o_index` and `o_group` hold.
- R6: The stored index is bits [7:0] of the returned register value. Bits [63:8] are ignored.
- R7: If the stored value is greater than L-1, `o_index` is L-1 and `oor_flag` becomes 1. The flag stays at 1 until the next capture start clears it.
- R8: `o_group` equals floor(step / L), computed from the raw step number.
- R9: Several entries that hold the same index are each returned unchanged, with no conflict detection.
- R10: A capture start during a capture aborts it. A response still in flight is discarded, and the new capture starts again at entry 0 of the new base and length.
- R11: After reset, `hazard_busy`, `rd_req_valid`, `o_valid`, `oor_flag` and `lk_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req | input | 1 | Index-setup command pulse |
| shape_wr | input | 1 | Shape configuration register write pulse |
| mvl_wr | input | 1 | Maximum vector length write pulse |
| cfg_base | input | 7 | First index register number, sampled at capture start |
| cfg_maxvl | input | 7 | Maximum vector length, sampled at capture start |
| rd_req_valid | output | 1 | Register-file read request valid |
| rd_req_ready | input | 1 | Read request grant |
| rd_req_addr | output | 7 | Register number to read |
| rd_rsp_valid | input | 1 | Read data return valid |
| rd_rsp_data | input | 64 | Returned register value |
| lk_valid | input | 1 | Step lookup valid |
| lk_ready | output | 1 | Step lookup accepted |
| lk_step | input | 10 | Raw element step number |
| o_valid | output | 1 | Remapped result valid |
| o_ready | input | 1 | Result consumer ready |
| o_index | output | 8 | Remapped index, clamped |
| o_group | output | 10 | Parallelism group of the step |
| hazard_busy | output | 1 | Capture in progress, index range hazarded |
| oor_flag | output | 1 | Sticky out-of-range index flag |

## Verification
A wrong count or pointer in the capture walk shows up on `rd_req_addr` as soon as the next request is granted. If the block stops early, `hazard_busy` falls too soon. If it stops late, `hazard_busy` stays high and no further requests follow. A stale or misplaced table entry, including one written by a response that an abort should have discarded, shows up one cycle after a lookup of that step is accepted, as a wrong `o_index`. A valid bit set too early shows up as a step accepted before its response was returned. The bench sweeps every step over two full periods of the length for a range of lengths and bases, including address wrap-around, duplicate and out-of-range values, and aborts while a response is in flight.

// File: rtl/ixr_pkg.sv
package ixr_pkg;

  // Capture walk states
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_FETCH = 2'd1,
    CAP_WAIT  = 2'd2,
    CAP_DRAIN = 2'd3
  } cap_state_e;

endpackage

// File: rtl/ixr_capture_seq.sv
module ixr_capture_seq
  import ixr_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int RADDR_W = 7,
  parameter int LEN_W   = 7,
  parameter int ENT_W   = 6,
  parameter int REG_DW  = 64,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]   maxvl_i,
  output logic               rd_req_valid_o,
  input  logic               rd_req_ready_i,
  output logic [RADDR_W-1:0] rd_req_addr_o,
  input  logic               rd_rsp_valid_i,
  input  logic [REG_DW-1:0]  rd_rsp_data_i,
  output logic               tbl_clr_o,
  output logic               tbl_we_o,
  output logic [ENT_W-1:0]   tbl_wa_o,
  output logic [IDX_W-1:0]   tbl_wd_o,
  output logic [LEN_W-1:0]   mvl_o,
  output logic               busy_o
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  cap_state_e         st_q;
  logic [LEN_W-1:0]   cnt_q;
  logic [RADDR_W-1:0] base_q;
  logic [LEN_W-1:0]   mvl_q;
  logic [LEN_W-1:0]   mvl_new;
  logic               req_fire;
  logic               in_flight;
  logic               unused_upper;

  assign unused_upper = ^rd_rsp_data_i[REG_DW-1:IDX_W];

  always_comb begin
    if (maxvl_i == '0)          mvl_new = LEN_ONE;
    else if (maxvl_i > LEN_MAX) mvl_new = LEN_MAX;
    else                        mvl_new = maxvl_i;
  end

  assign rd_req_valid_o = (st_q == CAP_FETCH);
  assign rd_req_addr_o  = base_q + RADDR_W'(cnt_q);
  assign req_fire       = rd_req_valid_o && rd_req_ready_i;

  // A request is still owed a response after this edge
  assign in_flight = (((st_q == CAP_WAIT) || (st_q == CAP_DRAIN)) && !rd_rsp_valid_i)
                   || req_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      cnt_q  <= '0;
      base_q <= '0;
      mvl_q  <= LEN_ONE;
    end else if (start_i) begin
      base_q <= base_i;
      mvl_q  <= mvl_new;
      cnt_q  <= '0;
      st_q   <= in_flight ? CAP_DRAIN : CAP_FETCH;
    end else begin
      unique case (st_q)
        CAP_FETCH: if (req_fire) begin
          cnt_q <= cnt_q + LEN_ONE;
          st_q  <= CAP_WAIT;
        end
        CAP_WAIT: if (rd_rsp_valid_i) begin
          st_q <= (cnt_q == mvl_q) ? CAP_IDLE : CAP_FETCH;
        end
        CAP_DRAIN: if (rd_rsp_valid_i) begin
          st_q <= CAP_FETCH;
        end
        default: ;
      endcase
    end
  end

  assign tbl_clr_o = start_i;
  assign tbl_we_o  = (st_q == CAP_WAIT) && rd_rsp_valid_i && !start_i;
  assign tbl_wa_o  = ENT_W'(cnt_q - LEN_ONE);
  assign tbl_wd_o  = rd_rsp_data_i[IDX_W-1:0];
  assign mvl_o     = mvl_q;
  assign busy_o    = (st_q != CAP_IDLE);

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i && !start_i) |=>
      (rd_req_valid_o && $stable(rd_req_addr_o)));

  assert_fetch_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_FETCH) |-> (cnt_q < mvl_q));

  assert_drain_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_DRAIN && rd_rsp_valid_i && !start_i) |=> (st_q == CAP_FETCH && cnt_q == '0));

endmodule

// File: rtl/ixr_index_table.sv
module ixr_index_table #(
  parameter int MAX_LEN = 64,
  parameter int ENT_W   = 6,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [ENT_W-1:0] wa_i,
  input  logic [IDX_W-1:0] wd_i,
  input  logic [ENT_W-1:0] ra_i,
  output logic [IDX_W-1:0] rd_o,
  output logic             rok_o
);

  logic             vld [MAX_LEN];
  logic [IDX_W-1:0] mem [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_entry
    logic hit;
    assign hit = we_i && (wa_i == ENT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld[g] <= 1'b0;
      else if (clr_i)  vld[g] <= 1'b0;
      else if (hit)    vld[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit && !clr_i) mem[g] <= wd_i;
    end
  end

  always_comb begin
    rok_o = 1'b0;
    rd_o  = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (ra_i == ENT_W'(i)) begin
        rok_o = vld[i];
        rd_o  = mem[i];
      end
    end
  end

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !rok_o);

endmodule

// File: rtl/ixr_lookup.sv
module ixr_lookup #(
  parameter int LEN_W  = 7,
  parameter int ENT_W  = 6,
  parameter int IDX_W  = 8,
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  mvl_i,
  input  logic              lk_valid_i,
  input  logic [STEP_W-1:0] lk_step_i,
  output logic              lk_ready_o,
  output logic [ENT_W-1:0]  ent_o,
  input  logic              ent_ok_i,
  input  logic [IDX_W-1:0]  ent_data_i,
  output logic              o_valid_o,
  input  logic              o_ready_i,
  output logic [IDX_W-1:0]  o_index_o,
  output logic [STEP_W-1:0] o_group_o,
  output logic              oor_o
);

  localparam int DW = (STEP_W > LEN_W) ? STEP_W : LEN_W;
  localparam int CW = (IDX_W > LEN_W) ? IDX_W : LEN_W;

  logic [LEN_W-1:0] mvl_s;
  logic [LEN_W-1:0] limit;
  logic [DW-1:0]    quo;
  logic [DW-1:0]    rem;
  logic             over;
  logic             accept;
  logic             unused_div;

  assign mvl_s = (mvl_i == '0) ? LEN_W'(1) : mvl_i;
  assign limit = mvl_s - LEN_W'(1);
  assign quo   = DW'(lk_step_i) / DW'(mvl_s);
  assign rem   = DW'(lk_step_i) % DW'(mvl_s);
  assign ent_o = ENT_W'(rem);
  assign over  = CW'(ent_data_i) > CW'(limit);
  assign unused_div = ^{quo, rem};

  assign lk_ready_o = !start_i && ent_ok_i && (!o_valid_o || o_ready_i);
  assign accept     = lk_valid_i && lk_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid_o <= 1'b0;
      o_index_o <= '0;
      o_group_o <= '0;
    end else if (accept) begin
      o_valid_o <= 1'b1;
      o_index_o <= over ? IDX_W'(limit) : ent_data_i;
      o_group_o <= STEP_W'(quo);
    end else if (o_ready_i) begin
      o_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                oor_o <= 1'b0;
    else if (start_i)          oor_o <= 1'b0;
    else if (accept && over)   oor_o <= 1'b1;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid_o && !o_ready_i) |=>
      (o_valid_o && $stable(o_index_o) && $stable(o_group_o)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> o_valid_o);

  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (CW'(o_index_o) <= CW'($past(limit))));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_o && !start_i) |=> oor_o);

endmodule

// File: rtl/idx_remap_cache.sv
module idx_remap_cache #(
  parameter int MAX_LEN = 64,
  parameter int RADDR_W = 7,
  parameter int REG_DW  = 64,
  parameter int IDX_W   = 8,
  parameter int STEP_W  = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_req,
  input  logic                         shape_wr,
  input  logic                         mvl_wr,
  input  logic [RADDR_W-1:0]           cfg_base,
  input  logic [$clog2(MAX_LEN+1)-1:0] cfg_maxvl,
  output logic                         rd_req_valid,
  input  logic                         rd_req_ready,
  output logic [RADDR_W-1:0]           rd_req_addr,
  input  logic                         rd_rsp_valid,
  input  logic [REG_DW-1:0]            rd_rsp_data,
  input  logic                         lk_valid,
  output logic                         lk_ready,
  input  logic [STEP_W-1:0]            lk_step,
  output logic                         o_valid,
  input  logic                         o_ready,
  output logic [IDX_W-1:0]             o_index,
  output logic [STEP_W-1:0]            o_group,
  output logic                         hazard_busy,
  output logic                         oor_flag
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int ENT_W = $clog2(MAX_LEN);

  logic             start;
  logic             tbl_clr;
  logic             tbl_we;
  logic [ENT_W-1:0] tbl_wa;
  logic [IDX_W-1:0] tbl_wd;
  logic [ENT_W-1:0] tbl_ra;
  logic [IDX_W-1:0] tbl_rd;
  logic             tbl_rok;
  logic [LEN_W-1:0] mvl;

  assign start = cap_req | shape_wr | mvl_wr;

  ixr_capture_seq #(
    .MAX_LEN(MAX_LEN), .RADDR_W(RADDR_W), .LEN_W(LEN_W),
    .ENT_W(ENT_W), .REG_DW(REG_DW), .IDX_W(IDX_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .base_i         (cfg_base),
    .maxvl_i        (cfg_maxvl),
    .rd_req_valid_o (rd_req_valid),
    .rd_req_ready_i (rd_req_ready),
    .rd_req_addr_o  (rd_req_addr),
    .rd_rsp_valid_i (rd_rsp_valid),
    .rd_rsp_data_i  (rd_rsp_data),
    .tbl_clr_o      (tbl_clr),
    .tbl_we_o       (tbl_we),
    .tbl_wa_o       (tbl_wa),
    .tbl_wd_o       (tbl_wd),
    .mvl_o          (mvl),
    .busy_o         (hazard_busy)
  );

  ixr_index_table #(
    .MAX_LEN(MAX_LEN), .ENT_W(ENT_W), .IDX_W(IDX_W)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (tbl_clr),
    .we_i  (tbl_we),
    .wa_i  (tbl_wa),
    .wd_i  (tbl_wd),
    .ra_i  (tbl_ra),
    .rd_o  (tbl_rd),
    .rok_o (tbl_rok)
  );

  ixr_lookup #(
    .LEN_W(LEN_W), .ENT_W(ENT_W), .IDX_W(IDX_W), .STEP_W(STEP_W)
  ) u_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .mvl_i      (mvl),
    .lk_valid_i (lk_valid),
    .lk_step_i  (lk_step),
    .lk_ready_o (lk_ready),
    .ent_o      (tbl_ra),
    .ent_ok_i   (tbl_rok),
    .ent_data_i (tbl_rd),
    .o_valid_o  (o_valid),
    .o_ready_i  (o_ready),
    .o_index_o  (o_index),
    .o_group_o  (o_group),
    .oor_o      (oor_flag)
  );

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hazard_busy && !start) |=> !rd_req_valid);

endmodule

// File: tb/test_idx_remap_cache.sv
module test_idx_remap_cache;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int FD         = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_req, shape_wr, mvl_wr;
  logic [6:0]  cfg_base;
  logic [6:0]  cfg_maxvl;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [6:0]  rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data  = '0;
  logic        lk_valid     = 1'b0;
  logic        lk_ready;
  logic [9:0]  lk_step      = '0;
  logic        o_valid;
  logic        o_ready      = 1'b0;
  logic [7:0]  o_index;
  logic [9:0]  o_group;
  logic        hazard_busy;
  logic        oor_flag;

  idx_remap_cache i_idx_remap_cache (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .shape_wr(shape_wr), .mvl_wr(mvl_wr),
    .cfg_base(cfg_base), .cfg_maxvl(cfg_maxvl),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_step(lk_step),
    .o_valid(o_valid), .o_ready(o_ready), .o_index(o_index), .o_group(o_group),
    .hazard_busy(hazard_busy), .oor_flag(oor_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Sequence-owned control
  int gen = 0, cur_mvl = 1, cur_base = 0, wrap = 3, step_off = 0;
  bit lk_go = 0;
  int seq_chk = 0, seq_fail = 0;
  int wd_fail = 0;

  // Monitor-owned state
  int seen_gen = 0, filled = 0, exp_k = 0, lk_idx = 0, cyc = 0;
  int mon_chk = 0, mon_fail = 0;
  bit pend = 0, lk_fired = 0, exp_flag = 0, lk_done = 0;
  int pend_dly = 0, pend_gen = 0;
  logic [63:0] pend_data = '0;
  int fifo_idx [FD];
  int fifo_grp [FD];
  int wp = 0, rp = 0;

  function automatic logic [63:0] make_reg(int addr, int g, int w);
    int low;
    low = (addr * 7 + g * 3) % w;
    return (64'(addr) * 64'h0123_4567_89AB_C000) | 64'(low);
  endfunction

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             seq_chk + mon_chk + wd_fail, seq_fail + mon_fail + wd_fail);
  endfunction

  // Monitor: drives at the falling edge, samples 1 time unit later
  always begin
    bit was_pend, trig;
    int s, e, v, ex;
    @(negedge clk);
    cyc++;
    if (seen_gen != gen) begin
      seen_gen = gen; filled = 0; exp_k = 0; lk_idx = 0;
      lk_fired = 0; lk_done = 0; exp_flag = 0;
    end
    if (lk_fired) begin
      mon_chk++;
      if (!o_valid) begin
        mon_fail++;
        $display("FAIL R5 latency: o_valid=%0d expected 1", o_valid);
      end
      lk_idx++;
      lk_fired = 0;
    end
    if (lk_go && lk_idx < 2 * cur_mvl + 3) begin
      lk_valid = 1'b1;
      lk_step  = 10'(lk_idx + step_off);
    end else begin
      lk_valid = 1'b0;
      if (lk_go) lk_done = 1;
    end
    was_pend = pend;
    rd_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_dly == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = pend_data;
        pend = 0;
        if (pend_gen == gen) filled++;
      end else begin
        pend_dly--;
      end
    end
    trig = cap_req | shape_wr | mvl_wr;
    rd_req_ready = !trig && (cyc % 3 != 0);
    o_ready      = (cyc % 4 != 1);
    #1;
    if (rd_req_valid && rd_req_ready) begin
      mon_chk++;
      if (was_pend) begin
        mon_fail++;
        $display("FAIL R2 outstanding: second request %0d expected none", rd_req_addr);
      end
      mon_chk++;
      ex = (cur_base + exp_k) % 128;
      if (int'(rd_req_addr) != ex || exp_k >= cur_mvl) begin
        mon_fail++;
        $display("FAIL R2 address: got %0d expected %0d (k=%0d L=%0d)",
                 rd_req_addr, ex, exp_k, cur_mvl);
      end
      pend = 1; pend_dly = LAT; pend_gen = gen;
      pend_data = make_reg(int'(rd_req_addr), gen, wrap);
      exp_k++;
    end
    if (o_valid && o_ready) begin
      mon_chk++;
      if (wp == rp) begin
        mon_fail++;
        $display("FAIL R5 output: unexpected result %0d expected none", o_index);
      end else begin
        if (int'(o_index) != fifo_idx[rp % FD]) begin
          mon_fail++;
          $display("FAIL R6 R7 R9 index: got %0d expected %0d", o_index, fifo_idx[rp % FD]);
        end
        mon_chk++;
        if (int'(o_group) != fifo_grp[rp % FD]) begin
          mon_fail++;
          $display("FAIL R8 group: got %0d expected %0d", o_group, fifo_grp[rp % FD]);
        end
        rp++;
      end
    end
    if (lk_valid && lk_ready) begin
      lk_fired = 1;
      s = lk_idx + step_off;
      e = s % cur_mvl;
      mon_chk++;
      if (e >= filled) begin
        mon_fail++;
        $display("FAIL R4 stall: entry %0d accepted with %0d stored, expected >%0d", e, filled, e);
      end
      v = int'(make_reg((cur_base + e) % 128, gen, wrap) & 64'hFF);
      if (v > cur_mvl - 1) begin
        ex = cur_mvl - 1;
        exp_flag = 1;
      end else begin
        ex = v;
      end
      fifo_idx[wp % FD] = ex;
      fifo_grp[wp % FD] = s / cur_mvl;
      wp++;
    end
  end

  task automatic chk(bit ok, string what, int got, int exp);
    seq_chk++;
    if (!ok) begin
      seq_fail++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic pulse(int trig);
    cap_req  = (trig == 0);
    shape_wr = (trig == 1);
    mvl_wr   = (trig == 2);
    @(posedge clk); #1;
    cap_req = 0; shape_wr = 0; mvl_wr = 0;
  endtask

  task automatic run_case(int mvl, int base, int trig, int wr, bit abort, int off);
    @(posedge clk); #1;
    lk_go = 0; gen++; cur_mvl = mvl; cur_base = base; wrap = wr; step_off = off;
    cfg_base = 7'(base); cfg_maxvl = 7'(mvl);
    pulse(trig);
    chk(hazard_busy == 1'b1, "R1 busy after start", int'(hazard_busy), 1);
    chk(lk_ready == 1'b0, "R1 entries cleared", int'(lk_ready), 0);
    if (abort) begin
      while (!(pend && pend_gen == gen && pend_dly == LAT)) begin
        @(posedge clk); #1;
      end
      gen++;
      pulse(0);
      chk(hazard_busy == 1'b1, "R10 busy after restart", int'(hazard_busy), 1);
    end
    lk_go = 1;
    while (!(lk_done && wp == rp && !hazard_busy && !o_valid)) begin
      @(posedge clk); #1;
    end
    chk(filled == mvl, "R3 all entries stored before busy falls", filled, mvl);
    chk(oor_flag == exp_flag, "R7 sticky flag", int'(oor_flag), int'(exp_flag));
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk(!rd_req_valid && !hazard_busy, "R3 quiet after capture", int'(rd_req_valid), 0);
    end
    lk_go = 0;
  endtask

  initial begin
    rst_n = 0; cap_req = 0; shape_wr = 0; mvl_wr = 0; cfg_base = '0; cfg_maxvl = 7'd1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk(hazard_busy == 0, "R11 reset busy", int'(hazard_busy), 0);
    chk(rd_req_valid == 0, "R11 reset request", int'(rd_req_valid), 0);
    chk(o_valid == 0, "R11 reset output", int'(o_valid), 0);
    chk(oor_flag == 0, "R11 reset flag", int'(oor_flag), 0);
    chk(lk_ready == 0, "R11 reset ready", int'(lk_ready), 0);
    run_case(4,  10,  0, 6,  0, 0);
    run_case(1,  0,   1, 3,  0, 0);
    run_case(2,  127, 2, 4,  0, 0);
    run_case(3,  5,   0, 3,  0, 0);
    run_case(5,  40,  1, 2,  0, 0);
    run_case(7,  60,  2, 9,  0, 0);
    run_case(8,  64,  0, 8,  1, 0);
    run_case(13, 20,  2, 15, 0, 900);
    run_case(16, 100, 1, 18, 0, 0);
    run_case(64, 0,   0, 66, 0, 0);
    run_case(64, 30,  1, 64, 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    summary();
    $finish;
  end

endmodule